// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of a synchronous DRAM burst. A one-cycle start strobe carries the start column and the burst settings: a length code, a wrap-order bit, a write flag and a write-single option. The block latches these and, from the next cycle on, presents one column per clock with a valid flag. A last flag marks the final beat of a fixed-length burst. A start may arrive on any cycle, including during a burst; the old burst ends at once and the new one takes over without a gap.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size. The order within the block is either counting up (sequential) or the start offset XOR the beat index (interleaved). Full-page bursts step through the whole column space and keep running until a new start or a stop input arrives. When the write-single option is set, write commands give one beat while reads keep the programmed length.

The controller is a three-state machine. `S_IDLE` outputs nothing. `S_FIXED` runs a burst of 1 to 8 beats. `S_PAGE` runs a full-page burst. There are five transitions. Start goes from any state to `S_FIXED` or `S_PAGE`, depending on the decoded length. The final beat takes `S_FIXED` to `S_IDLE`. Stop takes `S_FIXED` or `S_PAGE` to `S_IDLE`. Without a start or stop, `S_FIXED` stays put until its final beat and `S_PAGE` stays put indefinitely. Start has priority over stop.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, `beat_vld_o` and `last_o` are 0.
- R2: The length code sets the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The reserved codes 3'b100, 3'b101 and 3'b110 give 1 beat.
- R3: In sequential order (`interleave_i`=0), beat j of a burst of length L has low log2(L) bits equal to (start low bits + j) mod L. The upper column bits equal the start column's.
- R4: In interleaved order (`interleave_i`=1), beat j has low log2(L) bits equal to start low bits XOR j, with the upper bits unchanged. A full-page burst ignores the interleave bit.
- R5: In a full-page burst, the column rises by one each cycle and wraps from 2^COL_W-1 to 0. It continues until a start or stop is sampled.
- R6: `last_o` is 1 only on beat L-1 of a fixed burst. It is never 1 in a full-page burst and never 1 without `beat_vld_o`.
- R7: A start sampled on any cycle makes the next cycle show beat 0 at the start column with `beat_vld_o`=1. Any unfinished beats of the previous burst are dropped.
- R8: A stop sampled without a start makes `beat_vld_o` 0 in the next cycle. When start and stop are sampled together, the start wins.
- R9: When `wr_single_i`=1 and `is_write_i`=1 at start, the burst has exactly 1 beat whatever the length code. Reads, or writes with `wr_single_i`=0, keep the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start a burst with the settings below |
| start_col_i | input | COL_W | Start column |
| bl_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| is_write_i | input | 1 | The starting command is a write |
| wr_single_i | input | 1 | Writes are single-beat |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column of the current beat |
| beat_vld_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Final beat of a fixed burst |

## Verification
The bench uses the default COL_W of 10. With that width, a full-page burst started at 0x3FC crosses the top of the column space within a handful of beats, so the wrap to 0 is checked in a short run. A 10-bit column also leaves room for upper bits that must stay fixed while the low three bits wrap inside 8-beat bursts started near the top of the range.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIXED = 2'd1,
        S_PAGE  = 2'd2
    } bcs_state_e;

    localparam int unsigned MAX_LOG = 3;             // longest fixed burst is 2**MAX_LOG
    localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);

    typedef struct packed {
        logic [LOG_W-1:0] len_log;   // log2 of fixed burst length
        logic             page;      // full-page burst
    } bcs_len_t;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
    import bcs_pkg::*;
(
    input  logic [2:0] code_i,
    input  logic       is_write_i,
    input  logic       wr_single_i,
    output bcs_len_t   len_o
);
    always_comb begin
        len_o = '{len_log: '0, page: 1'b0};
        unique case (code_i)
            3'b001:  len_o.len_log = LOG_W'(1);
            3'b010:  len_o.len_log = LOG_W'(2);
            3'b011:  len_o.len_log = LOG_W'(3);
            3'b111:  len_o.page    = 1'b1;
            default: len_o.len_log = '0;   // 000 and reserved codes: one beat
        endcase
        if (is_write_i && wr_single_i) begin
            len_o = '{len_log: '0, page: 1'b0};
        end
    end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [LOG_W-1:0] len_log_i,
    input  logic             page_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    always_comb begin
        mask    = (COL_W'(1) << len_log_i) - COL_W'(1);
        seq_low = (base_i + beat_i) & mask;
        ilv_low = (base_i ^ beat_i) & mask;
        if (page_i) begin
            col_o = base_i + beat_i;
        end else if (ilv_i) begin
            col_o = (base_i & ~mask) | ilv_low;
        end else begin
            col_o = (base_i & ~mask) | seq_low;
        end
    end
endmodule

// File: rtl/bcs_beat_fsm.sv
module bcs_beat_fsm
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  bcs_len_t         len_i,
    input  logic             ilv_i,
    output bcs_state_e       state_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [LOG_W-1:0] len_log_o,
    output logic             page_o,
    output logic             ilv_o,
    output logic             vld_o,
    output logic             last_o
);
    bcs_state_e       st_q, st_d;
    logic [COL_W-1:0] base_q, beat_q, beat_d;
    logic [LOG_W-1:0] log_q;
    logic             ilv_q;
    logic [COL_W-1:0] final_beat;
    logic             at_final;

    assign final_beat = (COL_W'(1) << log_q) - COL_W'(1);
    assign at_final   = (beat_q == final_beat);

    // next state
    always_comb begin
        st_d   = st_q;
        beat_d = beat_q;
        if (start_i) begin
            st_d   = len_i.page ? S_PAGE : S_FIXED;
            beat_d = '0;
        end else begin
            unique case (st_q)
                S_IDLE:  st_d = S_IDLE;
                S_FIXED: begin
                    if (stop_i || at_final) st_d = S_IDLE;
                    else                    beat_d = beat_q + COL_W'(1);
                end
                S_PAGE: begin
                    if (stop_i) st_d = S_IDLE;
                    else        beat_d = beat_q + COL_W'(1);
                end
                default: st_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q   <= S_IDLE;
            beat_q <= '0;
            base_q <= '0;
            log_q  <= '0;
            ilv_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            beat_q <= beat_d;
            if (start_i) begin
                base_q <= start_col_i;
                log_q  <= len_i.page ? '0 : len_i.len_log;
                ilv_q  <= ilv_i && !len_i.page;
            end
        end
    end

    // outputs
    always_comb begin
        vld_o  = 1'b0;
        last_o = 1'b0;
        unique case (st_q)
            S_IDLE:  ;
            S_FIXED: begin vld_o = 1'b1; last_o = at_final; end
            S_PAGE:  vld_o = 1'b1;
            default: ;
        endcase
    end

    assign state_o   = st_q;
    assign base_o    = base_q;
    assign beat_o    = beat_q;
    assign len_log_o = log_q;
    assign page_o    = (st_q == S_PAGE);
    assign ilv_o     = ilv_q;

    // R6: no final marker in full-page state
    a_r6_no_last_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == S_PAGE) |-> !last_o);
    // R8: stop without start empties the next cycle
    a_r8_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !start_i) |=> (st_q == S_IDLE));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             wr_single_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o
);
    bcs_len_t         len_dec;
    bcs_state_e       state;
    logic [COL_W-1:0] base, beat;
    logic [LOG_W-1:0] len_log;
    logic             page, ilv;

    bcs_len_decode u_dec (
        .code_i      (bl_code_i),
        .is_write_i  (is_write_i),
        .wr_single_i (wr_single_i),
        .len_o       (len_dec)
    );

    bcs_beat_fsm #(.COL_W(COL_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .len_i       (len_dec),
        .ilv_i       (interleave_i),
        .state_o     (state),
        .base_o      (base),
        .beat_o      (beat),
        .len_log_o   (len_log),
        .page_o      (page),
        .ilv_o       (ilv),
        .vld_o       (beat_vld_o),
        .last_o      (last_o)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_col (
        .base_i    (base),
        .beat_i    (beat),
        .len_log_i (len_log),
        .page_i    (page),
        .ilv_i     (ilv),
        .col_o     (col_o)
    );

    // R6: final marker only with a valid beat
    a_r6_last_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |-> beat_vld_o);
    // R7: start shows its column next cycle
    a_r7_start_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (beat_vld_o && col_o == $past(start_col_i)));
    // R5: full page steps by one
    a_r5_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == S_PAGE && !start_i && !stop_i) |=> (col_o == $past(col_o) + COL_W'(1)));
    // R3: upper bits hold inside a fixed burst
    a_r3_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == S_FIXED && !last_o && !start_i && !stop_i) |=>
        (col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG])));
    // R1: nothing valid out of reset
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (!beat_vld_o && !last_o));
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
    localparam int COL_W = 10;

    typedef struct {
        logic [COL_W-1:0] col;
        logic             last;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] scol = '0;
    logic [2:0]       code = '0;
    logic             ilv = 1'b0;
    logic             wr = 1'b0;
    logic             single = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col;
    logic             vld, last;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
        .bl_code_i(code), .interleave_i(ilv), .is_write_i(wr),
        .wr_single_i(single), .stop_i(stop), .col_o(col),
        .beat_vld_o(vld), .last_o(last));

    function automatic int blen(input logic [2:0] c, input logic w, input logic s);
        int l;
        case (c)
            3'b000: l = 1;
            3'b001: l = 2;
            3'b010: l = 4;
            3'b011: l = 8;
            3'b111: l = 0;      // full page
            default: l = 1;
        endcase
        if (w && s) l = 1;
        return l;
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input int s, input int l, input int j, input logic il);
        int off, base;
        if (l == 0) return COL_W'((s + j) % (1 << COL_W));
        off  = s % l;
        base = s - off;
        if (il) return COL_W'(base + (off ^ j));
        return COL_W'(base + ((off + j) % l));
    endfunction

    // driver: queue expected beats, pulse start, hold for keep cycles
    task automatic go(input int s, input logic [2:0] c, input logic il, input logic w,
                      input logic sg, input int keep, input string tag);
        int l, n;
        exp_t e;
        l = blen(c, w, sg);
        n = (l == 0 || keep < l) ? keep : l;
        for (int j = 0; j < n; j++) begin
            e.col  = exp_col(s, l, j, il);
            e.last = (l != 0) && (j == l - 1);
            e.tag  = tag;
            q.push_back(e);
        end
        scol = COL_W'(s); code = c; ilv = il; wr = w; single = sg; start = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        repeat (keep - 1) @(negedge clk);
    endtask

    task automatic stop_pulse();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                if (vld) begin
                    checks++;
                    if (q.size() == 0) begin
                        fails++;
                        $display("FAIL extra beat (R2/R8) col=%h actual vld=1 expected vld=0", col);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        if (col !== e.col || last !== e.last) begin
                            fails++;
                            $display("FAIL %s col=%h last=%b expected col=%h last=%b",
                                     e.tag, col, last, e.col, e.last);
                        end
                    end
                end else if (q.size() != 0) begin
                    checks++;
                    fails++;
                    $display("FAIL %s missing beat actual vld=0 expected vld=1 col=%h",
                             q[0].tag, q[0].col);
                    void'(q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if (vld !== 1'b0 || last !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset vld=%b last=%b expected 0 0", vld, last);
        end
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        repeat (2) @(negedge clk);   // R1 idle after reset, monitor flags any beat

        go(10'h0A6, 3'b010, 1'b0, 1'b0, 1'b0, 4, "R3 seq BL4");
        repeat (2) @(negedge clk);
        go(10'h035, 3'b011, 1'b1, 1'b0, 1'b0, 8, "R4 ilv BL8");
        go(10'h3FE, 3'b011, 1'b0, 1'b0, 1'b0, 8, "R3 seq BL8 high");
        go(10'h123, 3'b000, 1'b0, 1'b0, 1'b0, 2, "R2 BL1");
        go(10'h101, 3'b001, 1'b1, 1'b0, 1'b0, 2, "R4 ilv BL2");
        go(10'h0F7, 3'b101, 1'b0, 1'b0, 1'b0, 3, "R2 reserved code");
        go(10'h3FC, 3'b111, 1'b1, 1'b0, 1'b0, 8, "R5 R6 full page wrap");
        stop_pulse();
        repeat (2) @(negedge clk);
        go(10'h048, 3'b011, 1'b0, 1'b0, 1'b0, 3, "R7 cut BL8");
        go(10'h2E1, 3'b010, 1'b1, 1'b0, 1'b0, 4, "R7 new start");
        go(10'h055, 3'b011, 1'b0, 1'b1, 1'b1, 3, "R9 write single");
        go(10'h055, 3'b011, 1'b0, 1'b0, 1'b1, 8, "R9 read keeps length");
        go(10'h1C0, 3'b010, 1'b0, 1'b1, 1'b0, 4, "R9 option clear");
        go(10'h0B3, 3'b011, 1'b1, 1'b0, 1'b0, 2, "R8 stop fixed");
        stop_pulse();
        repeat (2) @(negedge clk);
        go(10'h200, 3'b111, 1'b0, 1'b0, 1'b0, 3, "R5 page");
        stop = 1'b1;   // start and stop together: start wins
        go(10'h010, 3'b001, 1'b0, 1'b0, 1'b0, 2, "R8 start beats stop");
        repeat (4) @(negedge clk);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 leftover beats actual=%0d expected=0", q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule